// File: doc/BRIEF.md
# Memory controller status register file

This block is the software-visible register set of a DRAM memory controller. It holds three 32-bit words, each at its own word offset on a simple register bus with read and write strobes. Offset 0 captures errors (syndrome, failing page and three error-type flags). Offset 1 holds the ECC and diagnostic control bits. Offset 2 is a read-only configuration word that reports which memory boards are fitted. A read returns its data in the cycle after the strobe, together with an error flag. The error flag is raised when an offset does not exist.

The configuration word is fixed when the block is built, from a memory-size parameter. Small memories are counted in fine board units. Large memories are counted in coarse units and use only every other board slot. A side port from the ECC datapath records an error: it loads the syndrome and page and raises one flag. While any flag is still pending, the syndrome and page of the first error are kept.

Top module: `memctl_regs`

## Requirements
- R1: After reset, offset 0 and offset 1 read as zero, and offset 2 has bit 16 (restart flag) set, with bits 23:17 (start-address field) zero.
- R2: A read strobe at offset 0, 1 or 2 returns that register's value on `rd_data` in the following cycle.
- R3: A write to offset 1 keeps only bits 6:0, 25, 26, 27 and 28 of the written value. All other bits read back as zero.
- R4: A write to offset 0 clears each of bits 31:29 that is written as one. It leaves the other flags, the syndrome (bits 6:0) and the page (bits 23:9) unchanged.
- R5: A write to offset 2 changes nothing. A read of offset 2 always returns zero in bits 31:24.
- R6: A read or write at any offset above 2 sets `bus_err` in the following cycle, and such a read returns zero data. An access at offsets 0 to 2 clears `bus_err` in the following cycle.
- R7: When `MEM_KB` is 2048 or less, bits 15:0 of offset 2 hold (1 << (MEM_KB/128)) - 1, limited to 16 bits.
- R8: When `MEM_KB` is above 2048, bits 15:0 of offset 2 hold ((1 << (MEM_KB/512)) - 1) AND 0x5555, limited to 16 bits. The chip-size bit 24 is set internally but stays hidden on reads.
- R9: A capture with `cap_kind` 0, 1 or 2 sets flag bit 29, 30 or 31 respectively. If no flag was pending before the capture, it also loads `cap_syndrome` into bits 6:0 and `cap_page` into bits 23:9. `cap_kind` 3 is discarded.
- R10: A capture that arrives while any of bits 31:29 is set does not change the syndrome or the page.
- R11: A capture of kind 0 takes effect only while control bit 28 is one. Otherwise offset 0 is left unchanged.
- R12: When a capture and a write to offset 0 fall in the same cycle, the flag set by the capture remains set even if the write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| bus_err | output | 1 | Nonexistent-offset response, the cycle after a strobe |
| cap_valid | input | 1 | Error capture strobe |
| cap_kind | input | 2 | Capture type: 0 corrected, 1 substitute high, 2 substitute, 3 none |
| cap_syndrome | input | 7 | Syndrome of the captured error |
| cap_page | input | 15 | Page of the captured error |

## Verification
The bench builds three copies of the block that share one stimulus. The first uses `MEM_KB` = 1024, which exercises the fine-unit map (0x00FF). The second uses 5120, which exercises the alternating coarse-unit map (0x0155) and the hidden chip-size bit. The third uses 16384, which drives the coarse map into 16-bit saturation (0x5555). The capture tests order the writes to control bit 28 and to the flag bits so that the first-error hold, the kind-0 gating and the same-cycle set-over-clear case are each reached with a known register value.

// File: rtl/memctl_regs.sv
module memctl_regs #(
  parameter int MEM_KB = 1024,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              bus_err,
  input  logic              cap_valid,
  input  logic [1:0]        cap_kind,
  input  logic [6:0]        cap_syndrome,
  input  logic [14:0]       cap_page
);
  localparam int  SMALL_UNIT_KB = 128;
  localparam int  LARGE_UNIT_KB = 512;
  localparam int  LARGE_ABOVE_KB = 2048;
  localparam bit  LARGE = MEM_KB > LARGE_ABOVE_KB;
  localparam logic [31:0] CTRL_MASK = 32'h1E00_007F;

  function automatic logic [15:0] board_map(input int kb);
    int units;
    logic [15:0] m;
    units = (kb > LARGE_ABOVE_KB) ? kb / LARGE_UNIT_KB : kb / SMALL_UNIT_KB;
    if (units >= 16) m = 16'hFFFF;
    else             m = 16'((32'd1 << units) - 32'd1);
    if (kb > LARGE_ABOVE_KB) m = m & 16'h5555;
    return m;
  endfunction

  localparam logic [31:0] CFG_INIT = {7'd0, LARGE, 7'd0, 1'b1, board_map(MEM_KB)};

  logic [2:0]  flags;
  logic [6:0]  synd;
  logic [14:0] page;
  logic [31:0] ctrl;
  logic [31:0] cfg;
  logic [31:0] stat_word;

  logic sel0, sel1, sel2, hit;
  assign sel0 = addr == ADDR_W'(0);
  assign sel1 = addr == ADDR_W'(1);
  assign sel2 = addr == ADDR_W'(2);
  assign hit  = sel0 | sel1 | sel2;

  logic       cap_ok;
  logic [2:0] cap_set;
  logic [2:0] clr;
  assign cap_ok  = cap_valid && (cap_kind == 2'd1 || cap_kind == 2'd2 ||
                                 (cap_kind == 2'd0 && ctrl[28]));
  assign cap_set = cap_ok ? (3'b001 << cap_kind) : 3'b000;
  assign clr     = (wr_en && sel0) ? wr_data[31:29] : 3'b000;

  assign stat_word = {flags, 5'd0, page, 2'd0, synd};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      synd  <= '0;
      page  <= '0;
      ctrl  <= '0;
      cfg   <= CFG_INIT;
    end else begin
      flags <= (flags & ~clr) | cap_set;
      if (cap_ok && flags == 3'b000) begin
        synd <= cap_syndrome;
        page <= cap_page;
      end
      if (wr_en && sel1) ctrl <= wr_data & CTRL_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      bus_err <= 1'b0;
    end else begin
      if (rd_en) begin
        if (sel0)      rd_data <= stat_word;
        else if (sel1) rd_data <= ctrl;
        else if (sel2) rd_data <= {8'd0, cfg[23:0]};
        else           rd_data <= '0;
      end
      if (rd_en || wr_en) bus_err <= !hit;
    end
  end
endmodule

module memctl_regs_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              bus_err,
  input logic              cap_valid,
  input logic [1:0]        cap_kind,
  input logic [31:0]       stat_word,
  input logic [31:0]       ctrl
);
  assert_bad_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && addr > ADDR_W'(2) |=> bus_err);
  assert_good_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && addr <= ADDR_W'(2) |=> !bus_err);
  assert_cfg_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == ADDR_W'(2) |=> rd_data[31:24] == 8'd0);
  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(0) && !cap_valid |=>
      (stat_word[31:29] & $past(wr_data[31:29])) == 3'd0);
  assert_info_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(0) && !cap_valid |=> $stable(stat_word[23:0]));
  assert_first_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && stat_word[31:29] != 3'd0 |=> $stable(stat_word[23:0]));
  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && cap_kind == 2'd2 |=> stat_word[31]);
  assert_crd_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && cap_kind == 2'd0 && !ctrl[28] && !(wr_en && addr == ADDR_W'(0))
      |=> $stable(stat_word));
endmodule

bind memctl_regs memctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .bus_err(bus_err),
  .cap_valid(cap_valid), .cap_kind(cap_kind), .stat_word(stat_word), .ctrl(ctrl)
);

// File: tb/test_memctl_regs.sv
`timescale 1ns/1ps
module test_memctl_regs;
  logic clk = 0, rst_n = 0;
  logic rd_en = 0, wr_en = 0, cap_valid = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  cap_kind = '0;
  logic [6:0]  cap_syndrome = '0;
  logic [14:0] cap_page = '0;
  logic [31:0] rd_data, rd_b1, rd_b2;
  logic        bus_err, err_b1, err_b2;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  memctl_regs #(.MEM_KB(1024)) i_memctl_regs (.clk, .rst_n, .rd_en, .wr_en, .addr, .wr_data,
    .rd_data(rd_data), .bus_err(bus_err), .cap_valid, .cap_kind, .cap_syndrome, .cap_page);
  memctl_regs #(.MEM_KB(5120)) i_memctl_regs_b1 (.clk, .rst_n, .rd_en, .wr_en, .addr, .wr_data,
    .rd_data(rd_b1), .bus_err(err_b1), .cap_valid, .cap_kind, .cap_syndrome, .cap_page);
  memctl_regs #(.MEM_KB(16384)) i_memctl_regs_b2 (.clk, .rst_n, .rd_en, .wr_en, .addr, .wr_data,
    .rd_data(rd_b2), .bus_err(err_b2), .cap_valid, .cap_kind, .cap_syndrome, .cap_page);

  // {is_read, offset, write data, expected read data, expected bus_err}
  localparam int NV = 15;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 4'h0, 32'h0,        32'h0000_0000, 1'b0},  // R1 R2
    {1'b1, 4'h1, 32'h0,        32'h0000_0000, 1'b0},  // R1 R2
    {1'b1, 4'h2, 32'h0,        32'h0001_00FF, 1'b0},  // R1 R7
    {1'b0, 4'h1, 32'hFFFF_FFFF, 32'h0,        1'b0},  // R3
    {1'b1, 4'h1, 32'h0,        32'h1E00_007F, 1'b0},  // R3
    {1'b0, 4'h1, 32'h1234_5678, 32'h0,        1'b0},  // R3
    {1'b1, 4'h1, 32'h0,        32'h1200_0078, 1'b0},  // R3
    {1'b0, 4'h2, 32'hFFFF_FFFF, 32'h0,        1'b0},  // R5
    {1'b1, 4'h2, 32'h0,        32'h0001_00FF, 1'b0},  // R5
    {1'b1, 4'h3, 32'h0,        32'h0000_0000, 1'b1},  // R6
    {1'b0, 4'h7, 32'h0,        32'h0,        1'b1},  // R6
    {1'b1, 4'hF, 32'h0,        32'h0000_0000, 1'b1},  // R6
    {1'b0, 4'h0, 32'hFFFF_FFFF, 32'h0,        1'b0},  // R4
    {1'b1, 4'h0, 32'h0,        32'h0000_0000, 1'b0},  // R4
    {1'b0, 4'h1, 32'h0,        32'h0,        1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input bit rd, input logic [3:0] a, input logic [31:0] d,
                        input logic cap, input logic [1:0] k, input logic [6:0] s,
                        input logic [14:0] p);
    @(negedge clk);
    rd_en = rd; wr_en = !rd; addr = a; wr_data = d;
    cap_valid = cap; cap_kind = k; cap_syndrome = s; cap_page = p;
    @(negedge clk);
    rd_en = 0; wr_en = 0; cap_valid = 0;
  endtask

  task automatic capture(input logic [1:0] k, input logic [6:0] s, input logic [14:0] p);
    @(negedge clk);
    cap_valid = 1; cap_kind = k; cap_syndrome = s; cap_page = p;
    @(negedge clk);
    cap_valid = 0;
  endtask

  task automatic read_stat(input string req, input logic [31:0] exp);
    access(1, 4'h0, 32'h0, 0, 2'd0, 7'd0, 15'd0);
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    access(1, 4'h2, 32'h0, 0, 2'd0, 7'd0, 15'd0);
    chk("R8 map 5120KB", rd_b1, 32'h0001_0155);
    chk("R8 map 16384KB saturated", rd_b2, 32'h0001_5555);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][69], VEC[i][68:65], VEC[i][64:33], 0, 2'd0, 7'd0, 15'd0);
      if (VEC[i][69]) chk($sformatf("R2 vector %0d data", i), rd_data, VEC[i][32:1]);
      chk($sformatf("R6 vector %0d bus_err", i), {31'd0, bus_err}, {31'd0, VEC[i][0]});
    end

    access(0, 4'h1, 32'h1000_0000, 0, 2'd0, 7'd0, 15'd0);
    capture(2'd0, 7'h15, 15'h1234);
    read_stat("R9 R11 corrected capture", 32'h2024_6815);
    capture(2'd2, 7'h7F, 15'h7FFF);
    read_stat("R10 first error kept", 32'hA024_6815);
    access(0, 4'h0, 32'h2000_0000, 0, 2'd0, 7'd0, 15'd0);
    read_stat("R4 selective clear", 32'h8024_6815);
    access(0, 4'h0, 32'h8000_0000, 1, 2'd2, 7'h01, 15'h0001);
    read_stat("R12 set beats clear", 32'h8024_6815);
    access(0, 4'h0, 32'hE000_0000, 0, 2'd0, 7'd0, 15'd0);
    read_stat("R4 info survives clear", 32'h0024_6815);
    access(0, 4'h1, 32'h0, 0, 2'd0, 7'd0, 15'd0);
    capture(2'd0, 7'h33, 15'h0055);
    read_stat("R11 gated off", 32'h0024_6815);
    capture(2'd3, 7'h33, 15'h0055);
    read_stat("R9 kind 3 discarded", 32'h0024_6815);
    capture(2'd1, 7'h01, 15'h0002);
    read_stat("R9 substitute high", 32'h4000_0401);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule